// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block keeps the microprogram counter of a horizontally microcoded controller and computes its next value on every enabled clock edge. The current microinstruction supplies a 9-bit next-address field, a 2-bit branch-condition field and a 2-bit test-select field. The ALU supplies four internal flags (negative, zero, overflow, carry) and the instruction register supplies the current opcode byte. The counter is the control-store address.

The next address is never produced by incrementing. It is made by replacing low bits of the address field. A 2-way branch replaces the lowest bit with one selected flag. A 16-way dispatch replaces the low four bits with one half of the opcode. A dedicated halt microinstruction freezes the sequencer until reset.

A two-state controller governs the counter. In ST_RUN the counter loads on every edge where `run_en` is high. The transition T_STOP (ST_RUN to ST_HALT) is taken on an enabled edge that carries the halt marker. In ST_HALT the counter is frozen and the state holds (T_STAY) until reset. Reset always returns the controller to ST_RUN.

Top module: `mseq_sequencer`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) sets `upc` to 0 and `halted` to 0, with the controller in ST_RUN.
- R2: With condition code 0 (`cond_fld`=2'b00), an enabled edge loads `upc` with `addr_fld` unchanged.
- R3: With condition code 1, an enabled edge loads `upc` with `{addr_fld[8:1], f}`. Here f is the flag picked by `test_fld`: 0 picks `flag_n`, 1 picks `flag_z`, 2 picks `flag_v` and 3 picks `flag_c`. The flag is taken from the same cycle in which the fields are presented.
- R4: With condition code 2, an enabled edge loads `upc` with `{addr_fld[8:4], ir[7:4]}`.
- R5: With condition code 3, an enabled edge loads `upc` with `{addr_fld[8:4], ir[3:0]}`.
- R6: While `run_en` is low, `upc` holds its value whatever the other inputs are.
- R7: The halt marker is `addr_fld`=511, `cond_fld`=3 and `test_fld`=3, with every field at its maximum. An enabled edge carrying it takes T_STOP. `halted` is high after that edge, `upc` keeps its previous value, and the marker takes priority over condition-3 dispatch.
- R8: In ST_HALT, `halted` stays high and `upc` stays frozen for any input values until reset.
- R9: A reset applied while halted returns `upc` to 0 and `halted` to 0, and sequencing then resumes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Advances the counter on this edge when high |
| addr_fld | input | 9 | Next-address field of the current microinstruction |
| cond_fld | input | 2 | Branch-condition code |
| test_fld | input | 2 | Flag select for the 2-way branch |
| flag_n | input | 1 | ALU negative flag |
| flag_z | input | 1 | ALU zero flag |
| flag_v | input | 1 | ALU overflow flag |
| flag_c | input | 1 | ALU carry flag |
| ir | input | 8 | Instruction register (opcode byte) |
| upc | output | 9 | Microprogram counter / control-store address |
| halted | output | 1 | High once the halt microinstruction has been taken |

## Verification
The halt marker has condition code 3, the same code as the low-half opcode dispatch. Halt detection and dispatch can therefore fall on the same edge. The bench presents the marker with an `ir` value whose low nibble would send dispatch to a distinct address. It judges that `upc` keeps its old value rather than taking the dispatch target, and that `halted` rises. The bench also presents the marker while `run_en` is low, where neither function may act, and confirms that `halted` stays low and `upc` stays unchanged.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [1:0] {
        SEL_DIRECT = 2'd0,
        SEL_FLAG   = 2'd1,
        SEL_OP_HI  = 2'd2,
        SEL_OP_LO  = 2'd3
    } sel_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/mseq_addr_mux.sv
module mseq_addr_mux
    import mseq_pkg::*;
#(
    parameter int AW  = 9,
    parameter int IRW = 8,
    parameter int TW  = 2
) (
    input  logic [AW-1:0]      base,
    input  logic [1:0]         cond,
    input  logic [TW-1:0]      tsel,
    input  logic [(1<<TW)-1:0] flags,
    input  logic [IRW-1:0]     opcode,
    output logic [AW-1:0]      target
);
    localparam int NIB = IRW / 2;

    logic [NIB-1:0] op_hi;
    logic [NIB-1:0] op_lo;
    logic           pick;

    assign op_hi = opcode[IRW-1:NIB];
    assign op_lo = opcode[NIB-1:0];
    assign pick  = flags[tsel];

    always_comb begin
        unique case (sel_e'(cond))
            SEL_DIRECT: target = base;
            SEL_FLAG:   target = {base[AW-1:1], pick};
            SEL_OP_HI:  target = {base[AW-1:NIB], op_hi};
            SEL_OP_LO:  target = {base[AW-1:NIB], op_lo};
            default:    target = base;
        endcase
    end
endmodule

// File: rtl/mseq_halt_decode.sv
module mseq_halt_decode #(
    parameter int AW = 9,
    parameter int TW = 2
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    cond,
    input  logic [TW-1:0] tsel,
    output logic          marker
);
    always_comb begin
        marker = (&base) && (&cond) && (&tsel);
    end
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
    import mseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic marker,
    output logic load,
    output logic halted
);
    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (run_en && marker) state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        load   = 1'b0;
        halted = 1'b0;
        unique case (state_q)
            ST_RUN:  load = run_en && !marker;
            ST_HALT: halted = 1'b1;
            default: begin
                load   = 1'b0;
                halted = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer #(
    parameter int AW  = 9,
    parameter int IRW = 8,
    parameter int TW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic [AW-1:0]  addr_fld,
    input  logic [1:0]     cond_fld,
    input  logic [TW-1:0]  test_fld,
    input  logic           flag_n,
    input  logic           flag_z,
    input  logic           flag_v,
    input  logic           flag_c,
    input  logic [IRW-1:0] ir,
    output logic [AW-1:0]  upc,
    output logic           halted
);
    localparam int NFLAG = 1 << TW;

    logic [NFLAG-1:0] flag_vec;
    logic [AW-1:0]    target;
    logic             marker;
    logic             load;
    logic [AW-1:0]    upc_q;

    // Flag order follows the test-select encoding: N, Z, V, C.
    assign flag_vec = NFLAG'({flag_c, flag_v, flag_z, flag_n});

    mseq_addr_mux #(.AW(AW), .IRW(IRW), .TW(TW)) u_mux (
        .base   (addr_fld),
        .cond   (cond_fld),
        .tsel   (test_fld),
        .flags  (flag_vec),
        .opcode (ir),
        .target (target)
    );

    mseq_halt_decode #(.AW(AW), .TW(TW)) u_halt (
        .base   (addr_fld),
        .cond   (cond_fld),
        .tsel   (test_fld),
        .marker (marker)
    );

    mseq_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .marker (marker),
        .load   (load),
        .halted (halted)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    upc_q <= '0;
        else if (load) upc_q <= target;
    end

    assign upc = upc_q;
endmodule

// File: rtl/mseq_sequencer_chk.sv
module mseq_sequencer_chk #(
    parameter int AW  = 9,
    parameter int IRW = 8,
    parameter int TW  = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run_en,
    input logic [AW-1:0]  addr_fld,
    input logic [1:0]     cond_fld,
    input logic [TW-1:0]  test_fld,
    input logic [IRW-1:0] ir,
    input logic [AW-1:0]  upc,
    input logic           halted
);
    localparam int NIB = IRW / 2;

    logic mark_seen;
    logic live;
    assign mark_seen = (&addr_fld) && (&cond_fld) && (&test_fld);
    assign live      = run_en && !halted;

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cond_fld == 2'd0) |=> (upc == $past(addr_fld))); // R2

    AST_FLAG_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cond_fld == 2'd1) |=> (upc[AW-1:1] == $past(addr_fld[AW-1:1]))); // R3

    AST_OP_HI_NIB: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cond_fld == 2'd2) |=> (upc[NIB-1:0] == $past(ir[IRW-1:NIB]))); // R4

    AST_OP_LO_NIB: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cond_fld == 2'd3 && !mark_seen) |=> (upc[NIB-1:0] == $past(ir[NIB-1:0]))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !halted) |=> ($stable(upc) && !halted)); // R6

    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (live && mark_seen) |=> (halted && $stable(upc))); // R7

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(upc))); // R8
endmodule

bind mseq_sequencer mseq_sequencer_chk #(.AW(AW), .IRW(IRW), .TW(TW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .addr_fld (addr_fld),
    .cond_fld (cond_fld),
    .test_fld (test_fld),
    .ir       (ir),
    .upc      (upc),
    .halted   (halted)
);

// File: tb/mseq_sequencer_tb_top.sv
`timescale 1ns/1ps
module mseq_sequencer_tb_top;

    typedef struct {
        logic [8:0] upc;
        logic       halted;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [8:0] addr_fld = '0;
    logic [1:0] cond_fld = '0;
    logic [1:0] test_fld = '0;
    logic       flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic [7:0] ir = '0;
    logic [8:0] upc;
    logic       halted;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    logic [8:0] m_upc = '0;
    logic       m_halt = 1'b0;

    always #4 clk = ~clk;

    mseq_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .addr_fld(addr_fld), .cond_fld(cond_fld), .test_fld(test_fld),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .ir(ir), .upc(upc), .halted(halted)
    );

    task automatic check(input string tag, input logic [8:0] eu, input logic eh);
        n_run++;
        if (upc !== eu || halted !== eh) begin
            n_fail++;
            $display("FAIL %s: upc=%0d halted=%0b expected upc=%0d halted=%0b",
                     tag, upc, halted, eu, eh);
        end
    endtask

    // Driver: presents one microinstruction and pushes the expected result.
    task automatic step(input string tag, input logic run, input logic [8:0] a,
                        input logic [1:0] c, input logic [1:0] t,
                        input logic [3:0] nzvc, input logic [7:0] op);
        exp_t e;
        logic f;
        @(negedge clk);
        run_en = run; addr_fld = a; cond_fld = c; test_fld = t; ir = op;
        {flag_n, flag_z, flag_v, flag_c} = nzvc;
        unique case (t)
            2'd0: f = nzvc[3];
            2'd1: f = nzvc[2];
            2'd2: f = nzvc[1];
            default: f = nzvc[0];
        endcase
        if (!m_halt && run) begin
            if (a == 9'd511 && c == 2'd3 && t == 2'd3) m_halt = 1'b1;
            else begin
                unique case (c)
                    2'd0: m_upc = a;
                    2'd1: m_upc = {a[8:1], f};
                    2'd2: m_upc = {a[8:4], op[7:4]};
                    default: m_upc = {a[8:4], op[3:0]};
                endcase
            end
        end
        e.upc = m_upc; e.halted = m_halt; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares after each edge, away from the edge itself.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, e.upc, e.halted);
            end
        end
    end

    task automatic do_reset(input string tag);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(tag, 9'd0, 1'b0);
        m_upc = '0; m_halt = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1;
        check("R1 reset state", 9'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        step("R2 direct", 1, 9'd300, 2'd0, 2'd0, 4'b0000, 8'h00);
        step("R2 direct", 1, 9'd7,   2'd0, 2'd3, 4'b1111, 8'hFF);
        // R3: each test select, flag set and clear
        step("R3 N set",   1, 9'd100, 2'd1, 2'd0, 4'b1000, 8'h00);
        step("R3 N clear", 1, 9'd101, 2'd1, 2'd0, 4'b0111, 8'h00);
        step("R3 Z set",   1, 9'd200, 2'd1, 2'd1, 4'b0100, 8'h00);
        step("R3 Z clear", 1, 9'd201, 2'd1, 2'd1, 4'b1011, 8'h00);
        step("R3 V set",   1, 9'd40,  2'd1, 2'd2, 4'b0010, 8'h00);
        step("R3 C set",   1, 9'd510, 2'd1, 2'd3, 4'b0001, 8'h00);
        step("R3 C clear", 1, 9'd511, 2'd1, 2'd3, 4'b1110, 8'h00);
        // R4 / R5 dispatch
        step("R4 op high", 1, 9'd32,  2'd2, 2'd0, 4'b0000, 8'h6A);
        step("R4 op high", 1, 9'd495, 2'd2, 2'd1, 4'b0000, 8'h0F);
        step("R5 op low",  1, 9'd16,  2'd3, 2'd0, 4'b0000, 8'h6E);
        step("R5 op low",  1, 9'd511, 2'd3, 2'd2, 4'b0000, 8'h31);
        // R6 hold with run_en low, including a halt marker
        step("R6 idle hold",   0, 9'd5,   2'd0, 2'd0, 4'b1111, 8'hAA);
        step("R6 idle marker", 0, 9'd511, 2'd3, 2'd3, 4'b1111, 8'h05);
        step("R2 after idle",  1, 9'd77,  2'd0, 2'd0, 4'b0000, 8'h00);
        // R7: marker beats low-half dispatch
        step("R7 halt entry",  1, 9'd511, 2'd3, 2'd3, 4'b0000, 8'h05);
        // R8 frozen while halted
        step("R8 halted direct", 1, 9'd3,  2'd0, 2'd0, 4'b0000, 8'h00);
        step("R8 halted dispatch", 1, 9'd64, 2'd2, 2'd0, 4'b0000, 8'hC3);
        step("R8 halted idle", 0, 9'd9,   2'd1, 2'd1, 4'b0100, 8'h00);
        // R9 reset from halt, then resume
        do_reset("R9 reset from halt");
        step("R9 resume", 1, 9'd150, 2'd0, 2'd0, 4'b0000, 8'h00);
        step("R9 resume flag", 1, 9'd150, 2'd1, 2'd1, 4'b0100, 8'h00);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule